// File: doc/BRIEF.md
# Multicycle Load/Store Processor Datapath

This block is the registered datapath of a 32-bit processor that runs each instruction over several clock steps. It has one ALU and one memory port. Fetch and data access share the memory port. The ALU does the PC increment, the branch target, the effective address and the register-to-register arithmetic. The registers PC, instruction (IR), memory data (MDR), operand A, operand B and ALU result (ALUOut) hold values from one step to the next. A separate control sequencer, which is not part of this block, drives the enables and multiplexer selects every cycle. It reads back the opcode and function fields and the ALU zero flag.

The block contains a 32-entry, 32-bit register file and a small decoder that turns a 2-bit ALU request plus the function field into an ALU operation. Memory sits outside the block. Reads are combinational on `mem_rdata`. A write is requested by `mem_wr` at `mem_addr` with `mem_wdata`.

Top module: `mcd_top`

## Requirements
- R1: `mem_addr` equals PC when `addr_from_alu` is 0 and the held ALU result when it is 1. `mem_wdata` always carries operand B. `mem_wr` follows `mem_we` in the same cycle.
- R2: The first ALU operand is PC when `alu_a_reg` is 0 and operand A when it is 1.
- R3: The second ALU operand is chosen by `alu_b_sel`: 0 gives operand B, 1 gives the constant 4, 2 gives sign-extended IR[15:0], and 3 gives sign-extended IR[15:0] shifted left by two.
- R4: `alu_op` 0 adds and 1 subtracts. `alu_op` 2 takes the operation from IR[5:0]: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, and any other code adds. `alu_op` 3 adds. `alu_zero` is 1 exactly when the current ALU result is zero.
- R5: PC loads at a clock edge when `pc_we` is 1, or when `pc_we_cond` and `alu_zero` are both 1. Otherwise PC holds. The loaded value is set by `pc_src`: 0 the live ALU result, 1 the held ALU result, 2 {PC[31:28], IR[25:0], 2'b00}, and 3 the live ALU result.
- R6: IR loads `mem_rdata` only when `ir_we` is 1. `opcode` shows IR[31:26] and `funct` shows IR[5:0].
- R7: At every edge, A loads register IR[25:21] and B loads register IR[20:16]. Both reads use the register contents from before that edge's write.
- R8: When `rf_we` is 1, the register file writes at IR[15:11] if `rf_dst_rd` is 1, or at IR[20:16] if it is 0. The data is MDR if `rf_from_mem` is 1, or the held ALU result if it is 0.
- R9: Register 0 reads as zero, and writes to it have no effect.
- R10: At every edge, MDR loads `mem_rdata` and the held ALU result loads the live ALU result.
- R11: Synchronous active-high `rst` clears PC, IR, A, B, MDR, the held ALU result and every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pc_we | input | 1 | Unconditional PC load |
| pc_we_cond | input | 1 | PC load when the ALU result is zero |
| ir_we | input | 1 | Instruction register load |
| rf_we | input | 1 | Register file write |
| rf_dst_rd | input | 1 | Write index from IR[15:11] (1) or IR[20:16] (0) |
| rf_from_mem | input | 1 | Write data from MDR (1) or held ALU result (0) |
| addr_from_alu | input | 1 | Memory address from held ALU result (1) or PC (0) |
| alu_a_reg | input | 1 | First ALU operand from A (1) or PC (0) |
| alu_b_sel | input | 2 | Second ALU operand select |
| alu_op | input | 2 | ALU request: add, subtract, by function field |
| pc_src | input | 2 | Next-PC source select |
| mem_we | input | 1 | Memory write request |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data (operand B) |
| mem_wr | output | 1 | Memory write strobe |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |
| alu_zero | output | 1 | ALU result is zero |

## Verification
The bound checker checks several rules on every cycle. PC and IR hold when their enables are off. A or B becomes zero one edge after IR names register 0 as their source. Reset clears PC and IR. The arithmetic, the operand multiplexers, the register file write path and the next-PC choices depend on data, so the bench checks them. A behavioural model is fed the same random control words and random instruction memory, and it predicts the address, write data, strobe, IR fields and zero flag every cycle. Its instruction words use only register indices 0 to 3. This makes writes to register 0, reads of just-written registers and equal-operand compares frequent.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    localparam int XLEN     = 32;
    localparam int RF_DEPTH = 32;
    localparam int RF_AW    = $clog2(RF_DEPTH);
    localparam int IMM_W    = 16;

    // Instruction word; field positions are decoded by the datapath
    typedef struct packed {
        logic [5:0] op;
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] rd;
        logic [4:0] sh;
        logic [5:0] fn;
    } instr_t;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_AND = 2'd2,
        FN_OR  = 2'd3
    } alu_fn_e;

    typedef enum logic [1:0] {
        REQ_ADD   = 2'd0,
        REQ_SUB   = 2'd1,
        REQ_FIELD = 2'd2,
        REQ_SPARE = 2'd3
    } alu_req_e;

    typedef enum logic [1:0] {
        OPB_REG  = 2'd0,
        OPB_FOUR = 2'd1,
        OPB_IMM  = 2'd2,
        OPB_IMMW = 2'd3
    } opb_sel_e;

    typedef enum logic [1:0] {
        NPC_LIVE  = 2'd0,
        NPC_HELD  = 2'd1,
        NPC_JUMP  = 2'd2,
        NPC_SPARE = 2'd3
    } npc_sel_e;

    localparam logic [5:0] FC_ADD = 6'h20;
    localparam logic [5:0] FC_SUB = 6'h22;
    localparam logic [5:0] FC_AND = 6'h24;
    localparam logic [5:0] FC_OR  = 6'h25;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] jump_dest(input logic [3:0] pc_hi,
                                                  input instr_t   i);
        return {pc_hi, i.rs, i.rt, i.rd, i.sh, i.fn, 2'b00};
    endfunction

endpackage

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) cells[k] <= '0;
        end else begin
            // entry 0 is never written
            for (int k = 1; k < DEPTH; k++) begin
                if (we && wa == AW'(k)) cells[k] <= wd;
            end
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : cells[ra1];
    assign rd2 = (ra2 == '0) ? '0 : cells[ra2];

endmodule

// File: rtl/mcd_alu_ctrl.sv
module mcd_alu_ctrl
    import mcd_pkg::*;
(
    input  logic [1:0] req,
    input  logic [5:0] fcode,
    output alu_fn_e    fn
);
    always_comb begin
        unique case (alu_req_e'(req))
            REQ_SUB:   fn = FN_SUB;
            REQ_FIELD: begin
                case (fcode)
                    FC_SUB:  fn = FN_SUB;
                    FC_AND:  fn = FN_AND;
                    FC_OR:   fn = FN_OR;
                    default: fn = FN_ADD;
                endcase
            end
            default:   fn = FN_ADD;
        endcase
    end

endmodule

// File: rtl/mcd_alu.sv
module mcd_alu
    import mcd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (fn)
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mcd_top.sv
module mcd_top
    import mcd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pc_we,
    input  logic        pc_we_cond,
    input  logic        ir_we,
    input  logic        rf_we,
    input  logic        rf_dst_rd,
    input  logic        rf_from_mem,
    input  logic        addr_from_alu,
    input  logic        alu_a_reg,
    input  logic [1:0]  alu_b_sel,
    input  logic [1:0]  alu_op,
    input  logic [1:0]  pc_src,
    input  logic        mem_we,
    input  logic [31:0] mem_rdata,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic        mem_wr,
    output logic [5:0]  opcode,
    output logic [5:0]  funct,
    output logic        alu_zero
);
    logic [XLEN-1:0] pc_q, a_q, b_q, mdr_q, res_q;
    instr_t          ir_q;

    logic [XLEN-1:0] opa, opb, alu_y, imm_x, pc_d;
    logic [XLEN-1:0] rf_rd1, rf_rd2, rf_wd;
    logic [RF_AW-1:0] rf_wa;
    alu_fn_e         fn;
    logic            pc_load;

    // operand selection
    assign imm_x = sext_imm({ir_q.rd, ir_q.sh, ir_q.fn});
    assign opa   = alu_a_reg ? a_q : pc_q;

    always_comb begin
        unique case (opb_sel_e'(alu_b_sel))
            OPB_REG:  opb = b_q;
            OPB_FOUR: opb = XLEN'(4);
            OPB_IMM:  opb = imm_x;
            default:  opb = {imm_x[XLEN-3:0], 2'b00};
        endcase
    end

    mcd_alu_ctrl u_actl (
        .req   (alu_op),
        .fcode (ir_q.fn),
        .fn    (fn)
    );

    mcd_alu #(.W(XLEN)) u_alu (
        .a    (opa),
        .b    (opb),
        .fn   (fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // next PC
    always_comb begin
        unique case (npc_sel_e'(pc_src))
            NPC_HELD: pc_d = res_q;
            NPC_JUMP: pc_d = jump_dest(pc_q[XLEN-1:XLEN-4], ir_q);
            default:  pc_d = alu_y;
        endcase
    end

    assign pc_load = pc_we | (pc_we_cond & alu_zero);

    // register file
    assign rf_wa = rf_dst_rd ? ir_q.rd : ir_q.rt;
    assign rf_wd = rf_from_mem ? mdr_q : res_q;

    mcd_regfile #(.W(XLEN), .DEPTH(RF_DEPTH)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (ir_q.rs),
        .ra2 (ir_q.rt),
        .rd1 (rf_rd1),
        .rd2 (rf_rd2),
        .we  (rf_we),
        .wa  (rf_wa),
        .wd  (rf_wd)
    );

    // step registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ir_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            mdr_q <= '0;
            res_q <= '0;
        end else begin
            if (pc_load) pc_q <= pc_d;
            if (ir_we)   ir_q <= instr_t'(mem_rdata);
            a_q   <= rf_rd1;
            b_q   <= rf_rd2;
            mdr_q <= mem_rdata;
            res_q <= alu_y;
        end
    end

    // memory port and decode outputs
    assign mem_addr  = addr_from_alu ? res_q : pc_q;
    assign mem_wdata = b_q;
    assign mem_wr    = mem_we;
    assign opcode    = ir_q.op;
    assign funct     = ir_q.fn;

endmodule

// File: rtl/mcd_check.sv
module mcd_check (
    input logic        clk,
    input logic        rst,
    input logic        ir_we,
    input logic        pc_we,
    input logic        pc_we_cond,
    input logic        alu_zero,
    input logic [31:0] pc,
    input logic [31:0] ir,
    input logic [31:0] a,
    input logic [31:0] b
);
    assert_pc_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!pc_we && !(pc_we_cond && alu_zero)) |=> $stable(pc));

    assert_ir_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !ir_we |=> $stable(ir));

    assert_a_from_r0_R9: assert property (@(posedge clk) disable iff (rst)
        (ir[25:21] == 5'd0) |=> (a == 32'd0));

    assert_b_from_r0_R9: assert property (@(posedge clk) disable iff (rst)
        (ir[20:16] == 5'd0) |=> (b == 32'd0));

    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (pc == 32'd0 && ir == 32'd0 && a == 32'd0 && b == 32'd0));

endmodule

bind mcd_top mcd_check u_check (
    .clk        (clk),
    .rst        (rst),
    .ir_we      (ir_we),
    .pc_we      (pc_we),
    .pc_we_cond (pc_we_cond),
    .alu_zero   (alu_zero),
    .pc         (pc_q),
    .ir         (ir_q),
    .a          (a_q),
    .b          (b_q)
);

// File: tb/test_mcd_top.sv
module test_mcd_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst;
    logic        pc_we, pc_we_cond, ir_we, rf_we, rf_dst_rd, rf_from_mem;
    logic        addr_from_alu, alu_a_reg, mem_we;
    logic [1:0]  alu_b_sel, alu_op, pc_src;
    logic [31:0] mem_rdata, mem_addr, mem_wdata;
    logic        mem_wr, alu_zero;
    logic [5:0]  opcode, funct;

    logic [31:0] ram [256];
    assign mem_rdata = ram[mem_addr[9:2]];

    mcd_top i_mcd_top (
        .clk(clk), .rst(rst), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
        .ir_we(ir_we), .rf_we(rf_we), .rf_dst_rd(rf_dst_rd),
        .rf_from_mem(rf_from_mem), .addr_from_alu(addr_from_alu),
        .alu_a_reg(alu_a_reg), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
        .pc_src(pc_src), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wr(mem_wr),
        .opcode(opcode), .funct(funct), .alu_zero(alu_zero)
    );

    // behavioural reference state
    logic [31:0] m_pc, m_ir, m_a, m_b, m_mdr, m_res;
    logic [31:0] m_rf [32];
    bit          pend;
    int          pend_idx;
    logic [31:0] pend_data;
    int          n_run = 0, n_fail = 0;
    bit          finished = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] calc(input logic [31:0] x, input logic [31:0] y,
                                         input int op, input int fc);
        int kind;
        kind = 0;
        if (op == 1) kind = 1;
        if (op == 2) begin
            if (fc == 'h22) kind = 1;
            if (fc == 'h24) kind = 2;
            if (fc == 'h25) kind = 3;
        end
        if (kind == 1) return x - y;
        if (kind == 2) return x & y;
        if (kind == 3) return x | y;
        return x + y;
    endfunction

    task automatic step(input string tag, input int mode);
        logic [31:0] sa, sb, res, addr, rdat, npc;
        logic        z, load;
        int          widx;
        @(negedge clk);
        if (pend) ram[pend_idx] = pend_data;
        pend = 0;
        if (mode == 99) begin
            rst = 0;
            {pc_we, pc_we_cond, ir_we, rf_we, rf_dst_rd, rf_from_mem} = '0;
            {addr_from_alu, alu_a_reg, mem_we} = '0;
            {alu_b_sel, alu_op, pc_src} = '0;
        end else begin
            pc_we         = ($urandom % 4) == 0;
            pc_we_cond    = ($urandom % 4) == 0;
            ir_we         = $urandom % 2;
            rf_we         = $urandom % 2;
            rf_dst_rd     = $urandom % 2;
            rf_from_mem   = $urandom % 2;
            addr_from_alu = $urandom % 2;
            alu_a_reg     = $urandom % 2;
            mem_we        = ($urandom % 8) == 0;
            alu_b_sel     = 2'($urandom);
            alu_op        = (($urandom % 8) == 0) ? 2'd3 : 2'($urandom % 3);
            pc_src        = 2'($urandom);
            if (mode == 1) begin alu_b_sel = 2'd0; alu_op = 2'd0; end
            if (mode == 2) alu_op = 2'd0;
            if (mode == 3) begin pc_we = ($urandom % 8) == 0; pc_we_cond = 1; alu_op = 2'd1; end
            if (mode == 4) rf_we = 1;
        end
        #1;
        sa = alu_a_reg ? m_a : m_pc;
        case (alu_b_sel)
            2'd0: sb = m_b;
            2'd1: sb = 32'd4;
            2'd2: sb = sx(m_ir[15:0]);
            default: sb = sx(m_ir[15:0]) << 2;
        endcase
        res  = calc(sa, sb, int'(alu_op), int'(m_ir[5:0]));
        z    = (res == 0);
        addr = addr_from_alu ? m_res : m_pc;
        rdat = ram[addr[9:2]];
        chk(tag, "mem_addr", mem_addr, addr);
        chk(tag, "mem_wdata", mem_wdata, m_b);
        chk(tag, "mem_wr", {31'd0, mem_wr}, {31'd0, mem_we});
        chk(tag, "opcode/funct", {20'd0, opcode, funct}, {20'd0, m_ir[31:26], m_ir[5:0]});
        chk(tag, "alu_zero", {31'd0, alu_zero}, {31'd0, z});
        // next reference state for the coming edge
        if (mem_we) begin pend = 1; pend_idx = int'(addr[9:2]); pend_data = m_b; end
        load = pc_we || (pc_we_cond && z);
        if (pc_src == 2'd1)      npc = m_res;
        else if (pc_src == 2'd2) npc = {m_pc[31:28], m_ir[25:0], 2'b00};
        else                     npc = res;
        widx = rf_dst_rd ? int'(m_ir[15:11]) : int'(m_ir[20:16]);
        m_a = (m_ir[25:21] == 0) ? 32'd0 : m_rf[m_ir[25:21]];
        m_b = (m_ir[20:16] == 0) ? 32'd0 : m_rf[m_ir[20:16]];
        if (rf_we && widx != 0) m_rf[widx] = rf_from_mem ? m_mdr : m_res;
        if (load) m_pc = npc;
        if (ir_we) m_ir = rdat;
        m_mdr = rdat;
        m_res = res;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int fsel;
        for (int i = 0; i < 256; i++) begin
            fsel = $urandom % 5;
            ram[i] = {6'($urandom), 5'($urandom % 4), 5'($urandom % 4),
                      5'($urandom % 4), 5'd0,
                      (fsel == 0) ? 6'h20 : (fsel == 1) ? 6'h22 :
                      (fsel == 2) ? 6'h24 : (fsel == 3) ? 6'h25 : 6'($urandom)};
        end
        {m_pc, m_ir, m_a, m_b, m_mdr, m_res} = '0;
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        pend = 0;
        rst = 1;
        {pc_we, pc_we_cond, ir_we, rf_we, rf_dst_rd, rf_from_mem} = '0;
        {addr_from_alu, alu_a_reg, mem_we} = '0;
        {alu_b_sel, alu_op, pc_src} = '0;
        repeat (3) @(posedge clk);
        step("R11", 99);                                   // reset state
        for (int i = 0; i < 40; i++) step("R1", 0);        // address mux, strobe
        for (int i = 0; i < 40; i++) step("R2", 1);        // first operand
        for (int i = 0; i < 60; i++) step("R3", 2);        // second operand
        for (int i = 0; i < 60; i++) step("R4", 0);        // ALU ops and zero
        for (int i = 0; i < 80; i++) step("R5", 3);        // conditional PC
        for (int i = 0; i < 40; i++) step("R6", 0);        // IR load
        for (int i = 0; i < 40; i++) step("R7", 0);        // A/B every edge
        for (int i = 0; i < 80; i++) step("R8", 4);        // register writes
        for (int i = 0; i < 80; i++) step("R9", 4);        // register 0
        for (int i = 0; i < 60; i++) step("R10", 0);       // MDR / held result
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule